// File: doc/BRIEF.md
# Modified/Invalid private cache line controller

This block sits between one processor and a directory-based coherence fabric. It keeps a small direct-mapped array of lines. Each line is either absent (I) or held exclusively and possibly dirty (M). Because M is the only valid stable state, every miss of any kind asks the directory for an exclusive copy with a GETX request.

A single transaction buffer entry holds the transient state and the data of the line being worked on. For a miss it tracks the request until the data arrives. For a writeback it keeps a copy of the victim's data, so a forwarded GETX can still be served while the PUTX is waiting for the directory's answer. The processor sees pop and completion strobes, a hit flag and the read data. An eviction notice reports each line the controller loses.

Three input queues present their head words with a valid bit. The controller consumes at most one head per cycle. A head that cannot make progress stays where it is. Outgoing requests and outgoing data leave through fixed-latency delay lines.

Top module: `mi_l1_ctrl`

## Requirements
- R1: After reset every line is I, the transaction buffer is empty, `proto_err` is 0 and no output valid or pop is raised.
- R2: A processor request to a line in I is popped, and a GETX (`req_type` 0) for its address appears on the request channel REQ_DELAY cycles after the pop cycle. The request kind codes are 0 load, 1 instruction fetch, 2 store and 3 atomic. Codes 0 and 1 are reads; codes 2 and 3 are writes.
- R3: A processor request to a line in M completes in its pop cycle with `cpu_hit` 1. A read returns the stored word. A write replaces the stored word and returns the new one.
- R4: A data response for a line waiting on a read or write miss fills the line and moves it to M. It raises `cpu_done` with `cpu_hit` 0 and frees the buffer. `cpu_rdata` is the response word for a read miss and the processor's store word for a write miss.
- R5: These stall with their queue head left in place: a processor request to a line in a transient state, and a processor request that needs the buffer while the buffer is in use. A forwarded GETX or INV to a line still waiting on its miss data also stalls.
- R6: A forwarded GETX (`fwd_type` 0) to a line in M is popped. It raises the eviction notice for that address and sends the line word to `fwd_src` on the data channel RSP_DELAY cycles later. Afterwards the line is I.
- R7: A processor request whose set holds a different line in M is not popped. Instead the victim is copied into the buffer, a PUTX (`req_type` 1) carrying the victim address and word is issued, and the eviction notice names the victim. A forwarded INV (`fwd_type` 1) to a line in M does the same for that line and is popped.
- R8: While a PUTX is outstanding, the following apply:
  - WB_ACK (`fwd_type` 2) ends it and frees the buffer.
  - A GETX is served from the buffered word, and a later WB_NACK (`fwd_type` 3) then frees the buffer.
  - A WB_NACK received first makes the line wait. The next GETX is served from the buffer and frees it.
  - An INV is consumed with no output. An INV to a line in I is also consumed with no output.
- R9: At most one queue head is consumed per cycle. A forwarded request that can make progress goes first, then a data response, then a processor request. A stalled forwarded request does not block a response.
- R10: Any message that is illegal in the state of its line is consumed and sets `proto_err`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor queue head is present |
| cpu_kind | input | 2 | 0 load, 1 fetch, 2 store, 3 atomic |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_wdata | input | DATA_W | Word to write for store/atomic |
| cpu_pop | output | 1 | Processor head consumed this cycle |
| cpu_done | output | 1 | A processor access completes this cycle |
| cpu_hit | output | 1 | Completion was a hit (1) or a filled miss (0) |
| cpu_is_write | output | 1 | Completed access was a write |
| cpu_rdata | output | DATA_W | Line word after the completed access |
| fwd_valid | input | 1 | Forwarded queue head is present |
| fwd_type | input | 2 | 0 GETX, 1 INV, 2 WB_ACK, 3 WB_NACK |
| fwd_addr | input | ADDR_W | Line address of the forwarded message |
| fwd_src | input | ID_W | Requestor to receive forwarded data |
| fwd_pop | output | 1 | Forwarded head consumed this cycle |
| rsp_valid | input | 1 | Data response head is present |
| rsp_addr | input | ADDR_W | Line address of the response |
| rsp_data | input | DATA_W | Line word carried by the response |
| rsp_pop | output | 1 | Response head consumed this cycle |
| req_valid | output | 1 | Request to the directory is valid |
| req_type | output | 1 | 0 GETX, 1 PUTX |
| req_addr | output | ADDR_W | Request line address |
| req_data | output | DATA_W | Writeback word (PUTX) |
| dat_valid | output | 1 | Data message to another cache is valid |
| dat_addr | output | ADDR_W | Data message line address |
| dat_dest | output | ID_W | Destination requestor |
| dat_data | output | DATA_W | Line word sent |
| evict_valid | output | 1 | A line leaves this cache this cycle |
| evict_addr | output | ADDR_W | Address of the lost line |
| proto_err | output | 1 | Sticky illegal-message flag |

## Verification
The hardest situation to reach is a forwarded GETX arriving for a line whose miss data has not landed yet, in the same cycle as that data. The forwarded request must stall without hiding the response behind it. The bench drives both queue heads together, right after each miss, for every set. It then walks every writeback resolution order (ack, nack then GETX, GETX then nack, INV during a pending PUTX). To do this it first forces a victim by touching a second tag in the same set. Each data message is timed against the cycle in which its cause was consumed.

// File: rtl/mi_l1_pkg.sv
package mi_l1_pkg;

    typedef enum logic [2:0] {
        ST_I   = 3'd0,
        ST_M   = 3'd1,
        ST_IS  = 3'd2,
        ST_IM  = 3'd3,
        ST_MI  = 3'd4,
        ST_MII = 3'd5,
        ST_II  = 3'd6
    } lstate_e;

    localparam logic [1:0] CPU_LOAD   = 2'd0;
    localparam logic [1:0] CPU_FETCH  = 2'd1;
    localparam logic [1:0] CPU_STORE  = 2'd2;
    localparam logic [1:0] CPU_ATOMIC = 2'd3;

    localparam logic [1:0] FWD_GETX   = 2'd0;
    localparam logic [1:0] FWD_INV    = 2'd1;
    localparam logic [1:0] FWD_WBACK  = 2'd2;
    localparam logic [1:0] FWD_WBNACK = 2'd3;

    localparam logic REQ_GETX = 1'b0;
    localparam logic REQ_PUTX = 1'b1;

endpackage

// File: rtl/mi_l1_pipe.sv
module mi_l1_pipe #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic [DEPTH-1:0]        v_d, v_q;
    logic [DEPTH-1:0][W-1:0] p_d, p_q;

    always_comb begin
        v_d[0] = in_valid;
        p_d[0] = in_data;
        for (int i = 1; i < DEPTH; i++) begin
            v_d[i] = v_q[i-1];
            p_d[i] = p_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            p_q <= '0;
        end else begin
            v_q <= v_d;
            p_q <= p_d;
        end
    end

    assign out_valid = v_q[DEPTH-1];
    assign out_data  = p_q[DEPTH-1];
endmodule

// File: rtl/mi_l1_prio.sv
module mi_l1_prio #(
    parameter int N = 3
) (
    input  logic [N-1:0] want,
    output logic [N-1:0] grant
);
    always_comb begin
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (want[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mi_l1_ctrl.sv
module mi_l1_ctrl
    import mi_l1_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int IDX_W      = 2,
    parameter int DATA_W     = 16,
    parameter int ID_W       = 2,
    parameter int REQ_DELAY  = 2,
    parameter int RSP_DELAY  = 12,
    parameter bit SEND_EVICT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_kind,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_pop,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic              cpu_is_write,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              fwd_valid,
    input  logic [1:0]        fwd_type,
    input  logic [ADDR_W-1:0] fwd_addr,
    input  logic [ID_W-1:0]   fwd_src,
    output logic              fwd_pop,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              rsp_pop,
    output logic              req_valid,
    output logic              req_type,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              dat_valid,
    output logic [ADDR_W-1:0] dat_addr,
    output logic [ID_W-1:0]   dat_dest,
    output logic [DATA_W-1:0] dat_data,
    output logic              evict_valid,
    output logic [ADDR_W-1:0] evict_addr,
    output logic              proto_err
);
    localparam int SETS  = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int REQ_W = 1 + ADDR_W + DATA_W;
    localparam int DAT_W = ADDR_W + ID_W + DATA_W;

    typedef struct packed {
        logic              vld;
        lstate_e           st;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    typedef struct packed {
        logic              vld;
        lstate_e           st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } tbe_t;

    typedef struct packed {
        line_t [SETS-1:0] lines;
        tbe_t             tbe;
        logic             err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    function automatic lstate_e state_of(ctl_t c, logic [ADDR_W-1:0] a);
        line_t   l;
        lstate_e s;
        l = c.lines[a[IDX_W-1:0]];
        s = ST_I;
        if (c.tbe.vld && c.tbe.addr == a) begin
            s = c.tbe.st;
        end else if (l.vld && l.tag == a[ADDR_W-1:IDX_W]) begin
            s = l.st;
        end
        return s;
    endfunction

    // lookups and progress decisions
    lstate_e           f_st, r_st, c_st, v_st;
    line_t             c_line, f_line;
    logic              c_conflict, c_wr, tbe_free;
    logic [ADDR_W-1:0] vic_addr;
    logic              f_go, r_go, c_go;
    logic [2:0]        grant;

    // message strobes into the delay lines
    logic              rq_v;
    logic              rq_t;
    logic [ADDR_W-1:0] rq_a;
    logic [DATA_W-1:0] rq_dt;
    logic              dt_v;
    logic [ADDR_W-1:0] dt_a;
    logic [DATA_W-1:0] dt_dt;
    logic              ev_v;
    logic [ADDR_W-1:0] ev_a;

    always_comb begin
        f_st       = state_of(ctl_q, fwd_addr);
        r_st       = state_of(ctl_q, rsp_addr);
        c_st       = state_of(ctl_q, cpu_addr);
        c_line     = ctl_q.lines[cpu_addr[IDX_W-1:0]];
        f_line     = ctl_q.lines[fwd_addr[IDX_W-1:0]];
        c_wr       = (cpu_kind == CPU_STORE) || (cpu_kind == CPU_ATOMIC);
        c_conflict = c_line.vld && (c_line.tag != cpu_addr[ADDR_W-1:IDX_W]);
        vic_addr   = {c_line.tag, cpu_addr[IDX_W-1:0]};
        v_st       = state_of(ctl_q, vic_addr);
        tbe_free   = !ctl_q.tbe.vld;

        f_go = fwd_valid;
        if (f_st == ST_IS || f_st == ST_IM) begin
            if (fwd_type == FWD_GETX || fwd_type == FWD_INV) f_go = 1'b0;
        end
        if (fwd_type == FWD_INV && f_st == ST_M && !tbe_free) f_go = 1'b0;

        r_go = rsp_valid;

        c_go = 1'b0;
        if (cpu_valid) begin
            if (c_conflict) begin
                c_go = (v_st == ST_M) && tbe_free;
            end else if (c_st == ST_M) begin
                c_go = 1'b1;
            end else if (c_st == ST_I) begin
                c_go = tbe_free;
            end
        end
    end

    mi_l1_prio #(.N(3)) u_prio (
        .want  ({c_go, r_go, f_go}),
        .grant (grant)
    );

    always_comb begin
        ctl_d        = ctl_q;
        fwd_pop      = 1'b0;
        rsp_pop      = 1'b0;
        cpu_pop      = 1'b0;
        cpu_done     = 1'b0;
        cpu_hit      = 1'b0;
        cpu_is_write = 1'b0;
        cpu_rdata    = '0;
        rq_v         = 1'b0;
        rq_t         = REQ_GETX;
        rq_a         = '0;
        rq_dt        = '0;
        dt_v         = 1'b0;
        dt_a         = '0;
        dt_dt        = '0;
        ev_v         = 1'b0;
        ev_a         = '0;

        if (grant[0]) begin
            fwd_pop = 1'b1;
            unique case (fwd_type)
                FWD_GETX: begin
                    if (f_st == ST_M) begin
                        dt_v  = 1'b1;
                        dt_a  = fwd_addr;
                        dt_dt = f_line.data;
                        ev_v  = 1'b1;
                        ev_a  = fwd_addr;
                        ctl_d.lines[fwd_addr[IDX_W-1:0]].vld = 1'b0;
                    end else if (f_st == ST_MI) begin
                        dt_v  = 1'b1;
                        dt_a  = fwd_addr;
                        dt_dt = ctl_q.tbe.data;
                        ctl_d.tbe.st = ST_II;
                    end else if (f_st == ST_MII) begin
                        dt_v  = 1'b1;
                        dt_a  = fwd_addr;
                        dt_dt = ctl_q.tbe.data;
                        ctl_d.tbe.vld = 1'b0;
                    end else begin
                        ctl_d.err = 1'b1;
                    end
                end
                FWD_INV: begin
                    if (f_st == ST_M) begin
                        ctl_d.tbe = '{vld: 1'b1, st: ST_MI, addr: fwd_addr,
                                      data: f_line.data};
                        rq_v  = 1'b1;
                        rq_t  = REQ_PUTX;
                        rq_a  = fwd_addr;
                        rq_dt = f_line.data;
                        ev_v  = 1'b1;
                        ev_a  = fwd_addr;
                        ctl_d.lines[fwd_addr[IDX_W-1:0]].vld = 1'b0;
                    end else if (f_st != ST_I && f_st != ST_MI) begin
                        ctl_d.err = 1'b1;
                    end
                end
                FWD_WBACK: begin
                    if (f_st == ST_MI) ctl_d.tbe.vld = 1'b0;
                    else               ctl_d.err = 1'b1;
                end
                default: begin
                    if (f_st == ST_MI)      ctl_d.tbe.st  = ST_MII;
                    else if (f_st == ST_II) ctl_d.tbe.vld = 1'b0;
                    else                    ctl_d.err     = 1'b1;
                end
            endcase
        end else if (grant[1]) begin
            rsp_pop = 1'b1;
            if (r_st == ST_IS || r_st == ST_IM) begin
                cpu_done     = 1'b1;
                cpu_is_write = (r_st == ST_IM);
                cpu_rdata    = (r_st == ST_IM) ? ctl_q.tbe.data : rsp_data;
                ctl_d.lines[rsp_addr[IDX_W-1:0]].st   = ST_M;
                ctl_d.lines[rsp_addr[IDX_W-1:0]].data = cpu_rdata;
                ctl_d.tbe.vld = 1'b0;
            end else begin
                ctl_d.err = 1'b1;
            end
        end else if (grant[2]) begin
            if (c_conflict) begin
                // make room: victim leaves through a writeback
                ctl_d.tbe = '{vld: 1'b1, st: ST_MI, addr: vic_addr,
                              data: c_line.data};
                rq_v  = 1'b1;
                rq_t  = REQ_PUTX;
                rq_a  = vic_addr;
                rq_dt = c_line.data;
                ev_v  = 1'b1;
                ev_a  = vic_addr;
                ctl_d.lines[cpu_addr[IDX_W-1:0]].vld = 1'b0;
            end else if (c_st == ST_M) begin
                cpu_pop      = 1'b1;
                cpu_done     = 1'b1;
                cpu_hit      = 1'b1;
                cpu_is_write = c_wr;
                cpu_rdata    = c_wr ? cpu_wdata : c_line.data;
                ctl_d.lines[cpu_addr[IDX_W-1:0]].data = cpu_rdata;
            end else begin
                cpu_pop   = 1'b1;
                ctl_d.tbe = '{vld: 1'b1, st: c_wr ? ST_IM : ST_IS,
                              addr: cpu_addr, data: cpu_wdata};
                ctl_d.lines[cpu_addr[IDX_W-1:0]] =
                    '{vld: 1'b1, st: c_wr ? ST_IM : ST_IS,
                      tag: cpu_addr[ADDR_W-1:IDX_W], data: '0};
                rq_v = 1'b1;
                rq_t = REQ_GETX;
                rq_a = cpu_addr;
            end
        end

        if (!SEND_EVICT) ev_v = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign evict_valid = ev_v;
    assign evict_addr  = ev_a;
    assign proto_err   = ctl_q.err;

    mi_l1_pipe #(.W(REQ_W), .DEPTH(REQ_DELAY)) u_req_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rq_v),
        .in_data   ({rq_t, rq_a, rq_dt}),
        .out_valid (req_valid),
        .out_data  ({req_type, req_addr, req_data})
    );

    mi_l1_pipe #(.W(DAT_W), .DEPTH(RSP_DELAY)) u_dat_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (dt_v),
        .in_data   ({dt_a, fwd_src, dt_dt}),
        .out_valid (dat_valid),
        .out_data  ({dat_addr, dat_dest, dat_data})
    );
endmodule

// File: rtl/mi_l1_ctrl_chk.sv
module mi_l1_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic fwd_valid,
    input logic rsp_valid,
    input logic cpu_valid,
    input logic fwd_pop,
    input logic rsp_pop,
    input logic cpu_pop,
    input logic cpu_done,
    input logic cpu_hit,
    input logic evict_valid,
    input logic proto_err
);
    AST_ONE_CONSUMER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_pop, rsp_pop, cpu_pop}));                            // R9
    AST_POP_HAS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_pop |-> fwd_valid) and (rsp_pop |-> rsp_valid)
        and (cpu_pop |-> cpu_valid));                                      // R5
    AST_RSP_BEFORE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !fwd_pop |-> rsp_pop && !cpu_pop);                    // R9
    AST_HIT_WITH_POP: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done && cpu_hit |-> cpu_pop);                                  // R3
    AST_FILL_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done && !cpu_hit |-> rsp_pop);                                 // R4
    AST_VICTIM_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> !cpu_pop && !rsp_pop);                             // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);                                          // R10
endmodule

bind mi_l1_ctrl mi_l1_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fwd_valid   (fwd_valid),
    .rsp_valid   (rsp_valid),
    .cpu_valid   (cpu_valid),
    .fwd_pop     (fwd_pop),
    .rsp_pop     (rsp_pop),
    .cpu_pop     (cpu_pop),
    .cpu_done    (cpu_done),
    .cpu_hit     (cpu_hit),
    .evict_valid (evict_valid),
    .proto_err   (proto_err)
);

// File: tb/mi_l1_ctrl_test.sv
`timescale 1ns/1ps
module mi_l1_ctrl_test;
    localparam int AW = 4, DW = 16, IW = 2, RQD = 2, DTD = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    always #5 clk = ~clk;

    logic cpu_valid = 0; logic [1:0] cpu_kind = 0; logic [AW-1:0] cpu_addr = 0;
    logic [DW-1:0] cpu_wdata = 0;
    logic fwd_valid = 0; logic [1:0] fwd_type = 0; logic [AW-1:0] fwd_addr = 0;
    logic [IW-1:0] fwd_src = 0;
    logic rsp_valid = 0; logic [AW-1:0] rsp_addr = 0; logic [DW-1:0] rsp_data = 0;
    logic cpu_pop, cpu_done, cpu_hit, cpu_is_write, fwd_pop, rsp_pop;
    logic [DW-1:0] cpu_rdata, req_data, dat_data;
    logic req_valid, req_type, dat_valid, evict_valid, proto_err;
    logic [AW-1:0] req_addr, dat_addr, evict_addr;
    logic [IW-1:0] dat_dest;

    mi_l1_ctrl #(.ADDR_W(AW), .IDX_W(2), .DATA_W(DW), .ID_W(IW),
                 .REQ_DELAY(RQD), .RSP_DELAY(DTD), .SEND_EVICT(1'b1)) uut (.*);

    int n_chk = 0, n_fail = 0, cyc = 0, last_cyc = 0;
    logic sf, sr, sc, sdone, shit, swr, sev;
    logic [DW-1:0] srd;
    logic [AW-1:0] sea;
    int rq_n = 0, rq_cyc = 0, dt_n = 0, dt_cyc = 0;
    logic rq_t; logic [AW-1:0] rq_a, dt_a; logic [DW-1:0] rq_d, dt_d;
    logic [IW-1:0] dt_dst;

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (req_valid) begin
            rq_n++; rq_cyc = cyc; rq_t = req_type; rq_a = req_addr; rq_d = req_data;
        end
        if (dat_valid) begin
            dt_n++; dt_cyc = cyc; dt_a = dat_addr; dt_d = dat_data; dt_dst = dat_dest;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic step(input logic fv, input logic [1:0] ft, input logic [AW-1:0] fa,
                        input logic [IW-1:0] fs, input logic rv, input logic [AW-1:0] ra,
                        input logic [DW-1:0] rd, input logic cv, input logic [1:0] ck,
                        input logic [AW-1:0] ca, input logic [DW-1:0] cw);
        @(negedge clk);
        fwd_valid = fv; fwd_type = ft; fwd_addr = fa; fwd_src = fs;
        rsp_valid = rv; rsp_addr = ra; rsp_data = rd;
        cpu_valid = cv; cpu_kind = ck; cpu_addr = ca; cpu_wdata = cw;
        last_cyc = cyc;
        #1;
        sf = fwd_pop; sr = rsp_pop; sc = cpu_pop; sdone = cpu_done; shit = cpu_hit;
        swr = cpu_is_write; srd = cpu_rdata; sev = evict_valid; sea = evict_addr;
        @(posedge clk); #1;
        fwd_valid = 0; rsp_valid = 0; cpu_valid = 0;
    endtask

    task automatic cpu(input logic [1:0] k, input logic [AW-1:0] a, input logic [DW-1:0] w);
        step(0, 0, 0, 0, 0, 0, 0, 1, k, a, w);
    endtask
    task automatic fwd(input logic [1:0] t, input logic [AW-1:0] a, input logic [IW-1:0] s);
        step(1, t, a, s, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic rsp(input logic [AW-1:0] a, input logic [DW-1:0] d);
        step(0, 0, 0, 0, 1, a, d, 0, 0, 0, 0);
    endtask
    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        int c;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pops", {fwd_pop, rsp_pop, cpu_pop}, 0);
        chk("R1 outputs", {req_valid, dat_valid, evict_valid}, 0);
        chk("R1 err", proto_err, 0);
        rst_n = 1'b1;

        for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] a0, a1;
            logic [DW-1:0] w0, d0, v0, v1, d1;
            logic [1:0] k0;
            a0 = AW'(4 + s); a1 = AW'(8 + s); k0 = 2'(s);
            w0 = DW'(16'h1000 + s); d0 = DW'(16'h2000 + s);
            v1 = DW'(16'h3000 + s); d1 = DW'(16'h4000 + s);

            // R2 miss from I, all four request kinds across the sweep
            cpu(k0, a0, w0);
            c = last_cyc;
            chk("R2 miss pop", {sc, sdone}, 2'b10);
            cpu(k0, a0, w0);
            chk("R5 stall in IS/IM", sc, 0);
            idle(3);
            chk("R2 getx type", rq_t, 0);
            chk("R2 getx addr", rq_a, a0);
            chk("R2 getx delay", rq_cyc, c + RQD);

            // R9/R5 forwarded GETX stalls while the response passes
            step(1, 0, a0, 1, 1, a0, d0, 0, 0, 0, 0);
            v0 = (k0 >= 2) ? w0 : d0;
            chk("R9 fwd stalled", sf, 0);
            chk("R9 rsp taken", sr, 1);
            chk("R4 fill done", {sdone, shit, swr}, {2'b10, (k0 >= 2)});
            chk("R4 fill data", srd, v0);

            // R3 hits
            cpu(CPU_LOAD_K(), a0, 0);
            chk("R3 read hit", {sc, sdone, shit}, 3'b111);
            chk("R3 read data", srd, v0);
            cpu(2'd2, a0, v1);
            chk("R3 write hit", {shit, swr}, 2'b11);
            v0 = v1;
            cpu(2'd1, a0, 0);
            chk("R3 write kept", srd, v1);

            // R7 replacement on set conflict
            cpu(2'd1, a1, 0);
            c = last_cyc;
            chk("R7 no pop", sc, 0);
            chk("R7 evict", {sev, sea}, {1'b1, a0});
            idle(3);
            chk("R7 putx", {rq_t, rq_a, rq_d}, {1'b1, a0, v0});
            chk("R7 putx delay", rq_cyc, c + RQD);
            cpu(2'd1, a1, 0);
            chk("R5 buffer busy", sc, 0);

            // R8 all writeback endings
            case (s)
                0: begin
                    fwd(2'd2, a0, 0);
                    chk("R8 ack", sf, 1);
                end
                1: begin
                    fwd(2'd0, a0, 2);
                    c = last_cyc;
                    idle(DTD + 1);
                    chk("R8 getx in MI", {dt_a, dt_dst, dt_d}, {a0, 2'd2, v0});
                    chk("R8 data delay", dt_cyc, c + DTD);
                    fwd(2'd3, a0, 0);
                    chk("R8 nack in II", {sf, proto_err}, 2'b10);
                end
                2: begin
                    fwd(2'd1, a0, 0);
                    chk("R8 inv in MI", {sf, proto_err}, 2'b10);
                    fwd(2'd3, a0, 0);
                    c = dt_n;
                    fwd(2'd0, a0, 3);
                    idle(DTD + 1);
                    chk("R8 getx in MII", {dt_a, dt_dst, dt_d}, {a0, 2'd3, v0});
                    chk("R8 one data msg", dt_n, c + 1);
                end
                default: begin
                    fwd(2'd2, a0, 0);
                    c = rq_n;
                    fwd(2'd1, a0, 0);
                    idle(4);
                    chk("R8 inv in I", {sf, sev, proto_err}, 3'b100);
                    chk("R8 inv silent", rq_n, c);
                end
            endcase

            cpu(2'd1, a1, 0);
            chk("R2 miss after writeback", sc, 1);
            rsp(a1, d1);
            chk("R4 fetch fill", {sdone, srd}, {1'b1, d1});

            if (s % 2 == 0) begin
                // R6 / R9: forwarded GETX wins over a same-cycle processor request
                step(1, 0, a1, 1, 0, 0, 0, 1, 2'd0, a1, 0);
                c = last_cyc;
                chk("R9 fwd first", {sf, sc}, 2'b10);
                chk("R6 evict", {sev, sea}, {1'b1, a1});
                idle(DTD + 1);
                chk("R6 data", {dt_a, dt_dst, dt_d}, {a1, 2'd1, d1});
                chk("R6 data delay", dt_cyc, c + DTD);
                cpu(2'd0, a1, 0);
                chk("R6 line now I", {sc, sdone}, 2'b10);
                rsp(a1, d0);
                chk("R4 refill", srd, d0);
            end else begin
                fwd(2'd1, a1, 0);
                chk("R7 inv in M", {sf, sev, sea}, {2'b11, a1});
                idle(3);
                chk("R7 inv putx", {rq_t, rq_a, rq_d}, {1'b1, a1, d1});
                fwd(2'd2, a1, 0);
                chk("R8 ack after inv", {sf, proto_err}, 2'b10);
            end
        end

        // R10 illegal messages
        fwd(2'd2, 4'hF, 0);
        chk("R10 ack in I consumed", sf, 1);
        chk("R10 err set", proto_err, 1);
        fwd(2'd1, 4'hF, 0);
        chk("R10 err sticky", proto_err, 1);
        rsp(4'hF, 16'h5555);
        chk("R10 stray data", {sr, sdone, proto_err}, 3'b101);

        finish_run();
    end

    function automatic logic [1:0] CPU_LOAD_K();
        return 2'd0;
    endfunction
endmodule